// File: doc/BRIEF.md
# Bus Width Switch Controller

This block lets software move the external data bus between 8-bit and 16-bit operation after the system has booted. Out of reset the width is taken from a strap input. Software then programs an 8-bit control register holding a width choice and an arming bit. Setting the arming bit from 0 to 1 launches a short hardware sequence. The sequence asks the core arbiter for the internal bus and waits for the grant. While it holds the grant it updates the width output. It then drops its request and waits for the grant to go away.

The block does no per-cycle sizing of transfers and contains no memory interface. It only produces a stable width indication that the external bus logic uses. After the first completed switch the strap is no longer consulted. Each further switch needs the arming bit to be cleared and then set again.

Top module: `bwsw_ctrl`

## Requirements
- R1: The control register is 8 bits wide. Bit 6 is the width choice (0 = 8-bit bus, 1 = 16-bit bus) and bit 5 is the arming bit. Both are written by a write cycle and read back on `ctl_rdata`. Bit 7 and bits 4 to 0 always read 0.
- R2: Until the first switch completes, `wide_bus` equals `strap_wide` in the same cycle (1 = 16-bit).
- R3: A switch starts only on a write that sets bit 5 while the stored bit 5 is 0. A write with bit 5 = 1 while the stored bit is already 1, or any write with bit 5 = 0, starts nothing.
- R4: In the cycle after a starting write, `bus_req` goes high. It stays high until one cycle after `bus_gnt` is first seen high, and then falls.
- R5: `wide_bus` takes the sampled width choice on the clock edge that ends the cycle after the grant was seen, while `bus_gnt` is still held. It changes at no other time once switching has occurred.
- R6: After the first completed switch, changes on `strap_wide` have no effect on `wide_bus`.
- R7: The width choice is captured on the starting write. Writes to bit 6 during a running sequence only take effect at the next start.
- R8: `busy` is high from the cycle after the starting write until the cycle after `bus_gnt` is seen low with `bus_req` already low.
- R9: A 0-to-1 write of the arming bit while `busy` is high starts no new sequence, and no sequence follows once the current one ends.
- R10: While `rst_n` is low, all register bits, `bus_req` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| strap_wide | input | 1 | Boot width strap, 1 = 16-bit |
| bus_req | output | 1 | Internal bus request to core arbiter |
| bus_gnt | input | 1 | Internal bus grant from core arbiter |
| wide_bus | output | 1 | Effective bus width, 1 = 16-bit |
| busy | output | 1 | Switch sequence in progress |

## Verification
The bench rewrites the arming bit to 1 while it is already 1. A design that detects the level rather than the edge would steal the bus again at that point. It moves the strap after a switch, which catches a width mux that still follows the pin. It also sends width writes and a fresh arming edge in the middle of a slow grant. A design that samples the width late, or accepts a trigger while busy, would end on the wrong width or run a second sequence. Grant latencies of zero and of several cycles check that the width moves only under grant and that `busy` drops exactly after the grant is released.

// File: rtl/bwsw_pkg.sv
package bwsw_pkg;

  parameter int unsigned CTL_W    = 8;
  parameter int unsigned WSEL_POS = 6;
  parameter int unsigned EN_POS   = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_REQ     = 2'd1,
    SEQ_CHANGE  = 2'd2,
    SEQ_RELEASE = 2'd3
  } seq_st_e;

  // Bits of the control register that hold state; all others read zero.
  function automatic logic [CTL_W-1:0] ctl_keep_mask();
    logic [CTL_W-1:0] m;
    m = '0;
    m[WSEL_POS] = 1'b1;
    m[EN_POS]   = 1'b1;
    return m;
  endfunction

  // A start event: a write that sets the arming bit while it was clear.
  function automatic logic arm_rise(input logic old_en, input logic wr,
                                    input logic [CTL_W-1:0] wdata);
    return wr & wdata[EN_POS] & ~old_en;
  endfunction

  function automatic seq_st_e seq_step(input seq_st_e cur, input logic start,
                                       input logic gnt);
    seq_st_e nxt;
    nxt = cur;
    case (cur)
      SEQ_IDLE:    if (start) nxt = SEQ_REQ;
      SEQ_REQ:     if (gnt)   nxt = SEQ_CHANGE;
      SEQ_CHANGE:             nxt = SEQ_RELEASE;
      SEQ_RELEASE: if (!gnt)  nxt = SEQ_IDLE;
      default:                nxt = SEQ_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/bwsw_ctl_reg.sv
module bwsw_ctl_reg
  import bwsw_pkg::*;
#(
  parameter int unsigned W    = CTL_W,
  parameter int unsigned WSEL = WSEL_POS,
  parameter int unsigned EN   = EN_POS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         en_rise,
  output logic         wsel_in
);

  localparam logic [W-1:0] KEEP = ctl_keep_mask();

  logic [W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (wr) ctl_q <= wdata & KEEP;
  end

  assign rdata   = ctl_q;
  assign en_rise = arm_rise(ctl_q[EN], wr, wdata);
  assign wsel_in = wdata[WSEL];

endmodule

// File: rtl/bwsw_seq.sv
module bwsw_seq
  import bwsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wsel_in,
  input  logic bus_gnt,
  output logic bus_req,
  output logic busy,
  output logic load,
  output logic wsel_hold
);

  seq_st_e st_q, st_d;
  logic    samp_q;

  always_comb st_d = seq_step(st_q, start, bus_gnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      samp_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == SEQ_IDLE && start) samp_q <= wsel_in;
    end
  end

  assign bus_req   = (st_q == SEQ_REQ) || (st_q == SEQ_CHANGE);
  assign busy      = (st_q != SEQ_IDLE);
  assign load      = (st_q == SEQ_CHANGE);
  assign wsel_hold = samp_q;

endmodule

// File: rtl/bwsw_width_hold.sv
module bwsw_width_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic wsel_hold,
  input  logic strap_wide,
  output logic wide_bus,
  output logic switched
);

  logic width_q;
  logic sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= 1'b0;
      sw_q    <= 1'b0;
    end else if (load) begin
      width_q <= wsel_hold;
      sw_q    <= 1'b1;
    end
  end

  assign wide_bus = sw_q ? width_q : strap_wide;
  assign switched = sw_q;

endmodule

// File: rtl/bwsw_ctrl.sv
module bwsw_ctrl
  import bwsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             strap_wide,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             wide_bus,
  output logic             busy
);

  // Internal events, named for the checker.
  logic trig_evt;
  logic wsel_in;
  logic width_load;
  logic wsel_hold;
  logic switched;

  bwsw_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctl_wr),
    .wdata   (ctl_wdata),
    .rdata   (ctl_rdata),
    .en_rise (trig_evt),
    .wsel_in (wsel_in)
  );

  bwsw_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (trig_evt),
    .wsel_in   (wsel_in),
    .bus_gnt   (bus_gnt),
    .bus_req   (bus_req),
    .busy      (busy),
    .load      (width_load),
    .wsel_hold (wsel_hold)
  );

  bwsw_width_hold u_width (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (width_load),
    .wsel_hold  (wsel_hold),
    .strap_wide (strap_wide),
    .wide_bus   (wide_bus),
    .switched   (switched)
  );

endmodule

// File: rtl/bwsw_chk.sv
module bwsw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig_evt,
  input logic       width_load,
  input logic       switched,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       busy,
  input logic       wide_bus,
  input logic [7:0] ctl_rdata
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[7] == 1'b0) && (ctl_rdata[4:0] == 5'd0)); // R1

  AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt && !busy |=> bus_req && busy); // R4

  AST_REQ_DROP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(width_load)); // R4

  AST_LOAD_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    width_load |-> bus_gnt && bus_req); // R5

  AST_WIDTH_MOVES_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    switched && $past(switched) && !$stable(wide_bus) |-> $past(width_load)); // R5

  AST_STRAP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    switched && $past(switched) && !$past(width_load) |-> $stable(wide_bus)); // R6

  AST_REQ_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy); // R8

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_req && !bus_gnt |=> !busy); // R8

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_req && !bus_gnt |=> !bus_req); // R9

endmodule

bind bwsw_ctrl bwsw_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_evt   (trig_evt),
  .width_load (width_load),
  .switched   (switched),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .busy       (busy),
  .wide_bus   (wide_bus),
  .ctl_rdata  (ctl_rdata)
);

// File: tb/bwsw_ctrl_tb.sv
module bwsw_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       strap_wide = 1'b0;
  logic       bus_req;
  logic       bus_gnt = 1'b0;
  logic       wide_bus;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int gnt_lat = 1;
  int gnt_cnt = 0;

  // Reference model state
  int m_phase = 0;     // 0 idle,1 asking,2 owns bus,3 giving back
  bit m_en = 0, m_wsel = 0, m_samp = 0, m_width = 0, m_done = 0;

  always #5 clk = ~clk;

  bwsw_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .strap_wide(strap_wide), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .wide_bus(wide_bus), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Behavioural model, advanced on each rising edge.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_en = 0; m_wsel = 0; m_samp = 0; m_width = 0; m_done = 0;
    end else begin
      bit start;
      start = ctl_wr && ctl_wdata[5] && !m_en;
      if (ctl_wr) begin m_en = ctl_wdata[5]; m_wsel = ctl_wdata[6]; end
      if (m_phase == 0) begin
        if (start) begin m_phase = 1; m_samp = ctl_wdata[6]; end
      end else if (m_phase == 1) begin
        if (bus_gnt) m_phase = 2;
      end else if (m_phase == 2) begin
        m_width = m_samp; m_done = 1; m_phase = 3;
      end else begin
        if (!bus_gnt) m_phase = 0;
      end
    end
  end

  function automatic int exp_wide();
    return m_done ? int'(m_width) : int'(strap_wide);
  endfunction

  // Per-cycle comparison, away from both edges.
  always @(posedge clk) begin
    #3;
    check("R1 rdata", ctl_rdata, {1'b0, m_wsel, m_en, 5'b0});
    check("R4 bus_req", bus_req, (m_phase == 1 || m_phase == 2));
    check("R8 busy", busy, (m_phase != 0));
    check("R5 wide_bus", wide_bus, exp_wide());
  end

  // Arbiter: grants after gnt_lat cycles, releases after gnt_lat cycles.
  always @(negedge clk) begin
    if (bus_req != bus_gnt) begin
      if (gnt_cnt >= gnt_lat) begin bus_gnt <= bus_req; gnt_cnt <= 0; end
      else gnt_cnt <= gnt_cnt + 1;
    end else gnt_cnt <= 0;
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  task automatic settle();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!busy && !bus_gnt) break;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rdata", ctl_rdata, 0);
    check("R10 bus_req", bus_req, 0);
    check("R10 busy", busy, 0);
    check("R2 strap low", wide_bus, 0);
    strap_wide = 1'b1; #1;
    check("R2 strap high", wide_bus, 1);
    rst_n = 1'b1;
    @(negedge clk);
    strap_wide = 1'b0;
    wr(8'hFF);                         // only bits 6,5 kept; starts switch
    check("R1 masked read", ctl_rdata, 8'h60);
    settle();
    check("R5 switched to 16", wide_bus, 1);
    strap_wide = 1'b1; @(negedge clk); strap_wide = 1'b0; @(negedge clk);
    check("R6 strap ignored", wide_bus, 1);
    wr(8'h20);                         // enable already 1: no start
    repeat (3) @(negedge clk);
    check("R3 no level trigger", busy, 0);
    check("R3 width kept", wide_bus, 1);
    wr(8'h00); wr(8'h40);              // width only, no enable
    repeat (3) @(negedge clk);
    check("R3 no start w/o enable", busy, 0);
    gnt_lat = 0;
    wr(8'h20);                         // 0->1 edge, 8-bit
    settle();
    check("R5 switched to 8 fast grant", wide_bus, 0);
    gnt_lat = 6;
    wr(8'h00); wr(8'h60);              // start, sample 16-bit
    check("R8 busy after start", busy, 1);
    wr(8'h00); wr(8'h20);              // width write + rising edge while busy
    check("R9 still in first run", busy, 1);
    settle();
    check("R7 sampled width used", wide_bus, 1);
    repeat (4) @(negedge clk);
    check("R9 no second run", busy, 0);
    check("R9 width unchanged", wide_bus, 1);
    check("R7 reg holds late write", ctl_rdata, 8'h20);
    gnt_lat = 2;
    wr(8'h00); wr(8'h20);
    settle();
    check("R5 switched to 8 again", wide_bus, 0);
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule